// File: doc/BRIEF.md
# ASCII Frame Longitudinal Check Engine

This block takes a colon-delimited ASCII frame, one character per cycle, over a valid/ready character stream. Each pair of hex characters is decoded into a binary byte, high nibble first. The block keeps a modulo-256 running sum of the decoded address, command and data bytes. The final decoded byte before the CR LF terminator is the two-character check field. When LF arrives, the block confirms that the check equals the two's-complement negation of the sum. It then raises a one-cycle pass or mismatch pulse, together with a frame-done pulse. Malformed input raises a format-error pulse instead.

The received check byte must not be added to the sum. For that reason, each decoded byte is held in a one-byte buffer. A byte is added to the sum only when a later hex pair shows that it was not the last byte. On the transmit side, a start pulse makes the block emit the negation of everything decoded so far since the colon. It is sent as two upper-case hex characters on a second valid/ready stream. Input is stalled while those two characters go out.

Top module: `ascii_lrc_engine`

## Requirements
- R1: Synchronous active-high reset drops all outputs low and returns the block to waiting for a colon (3AH). Characters that arrive before a colon, including hex digits, CR (0DH) and LF (0AH), produce no output pulse.
- R2: For a frame ':' followed by hex pairs and then CR LF, the block checks the last pair against the negated sum. If the last pair equals the two's-complement negation of the modulo-256 sum of all earlier pairs, frame_done and frame_ok pulse for one cycle, in the cycle after LF is accepted. An example is ":010304010001F6" followed by CR LF, where the sum is 0AH and the check is F6H.
- R3: A check that differs from the negated sum makes frame_done and lrc_error pulse together, and frame_ok stays low.
- R4: The hex letters a-f are accepted on receive and give the same values as A-F.
- R5: Any character other than a hex digit, CR or colon where a high nibble is expected, or other than a hex digit or colon where a low nibble is expected, pulses fmt_error. The frame is then dropped, and the block waits for a new colon.
- R6: A CR that arrives after an odd number of hex characters pulses fmt_error and drops the frame. A CR LF with no hex pair at all also pulses fmt_error, at the LF, with no frame_done.
- R7: A colon inside a frame pulses fmt_error and starts a new frame at once. A correct frame that follows it then completes with frame_ok.
- R8: A tx_start pulse, while the transmitter is idle, emits the negation of the sum of all bytes decoded since the colon, including the buffered byte. It is sent as two upper-case hex characters on tx_data, high nibble first. in_ready is low while either character is pending.
- R9: While tx_valid is high and tx_ready is low, tx_data holds its value and tx_valid stays high.
- R10: frame_done rises only in the cycle after an LF has been accepted. frame_ok and lrc_error are never high together. fmt_error is never high together with frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive character valid |
| in_data | input | 8 | Receive ASCII character |
| in_ready | output | 1 | Receive character accepted; low while transmitting |
| tx_start | input | 1 | Pulse to emit the computed check characters |
| tx_valid | output | 1 | Transmit character valid |
| tx_data | output | 8 | Transmit ASCII hex character |
| tx_ready | input | 1 | Transmit character taken by the sink |
| frame_done | output | 1 | One-cycle pulse: terminator LF accepted on a frame with a check byte |
| frame_ok | output | 1 | One-cycle pulse: check matched |
| lrc_error | output | 1 | One-cycle pulse: check mismatched |
| fmt_error | output | 1 | One-cycle pulse: malformed frame aborted |

## Verification
The assertions check the pulse relations on every cycle. frame_done appears only after an accepted LF, frame_ok implies frame_done, and pass and mismatch are exclusive, as are format error and done. They also check that transmitted characters are upper-case hex and are held steady under backpressure. Only the bench scenarios can show that the arithmetic is right, because that depends on whole character sequences. These scenarios cover whether the check byte is kept out of the sum, lower-case acceptance, and the abort and restart paths for stray, odd-count and mid-frame colon input. They also cover the exact check value produced by the transmitter.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    localparam int CHAR_W = 8;
    localparam int NIB_W  = CHAR_W / 2;

    localparam logic [CHAR_W-1:0] CH_COLON = 8'h3A;
    localparam logic [CHAR_W-1:0] CH_CR    = 8'h0D;
    localparam logic [CHAR_W-1:0] CH_LF    = 8'h0A;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HI,
        RX_LO,
        RX_LF
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_OFF,
        TX_HI,
        TX_LO
    } tx_phase_t;

    typedef struct packed {
        rx_state_t         st;
        logic [NIB_W-1:0]  nib;
        logic [CHAR_W-1:0] sum;
        logic [CHAR_W-1:0] pend;
        logic              pend_v;
        logic              done;
        logic              ok;
        logic              lrc_err;
        logic              fmt_err;
        tx_phase_t         tx_ph;
        logic [CHAR_W-1:0] tx_byte;
    } lrc_state_t;
endpackage

// File: rtl/lrc_hex_decode.sv
module lrc_hex_decode
    import lrc_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output logic              is_hex,
    output logic [NIB_W-1:0]  nib
);
    logic [CHAR_W-1:0] diff;

    always_comb begin
        is_hex = 1'b0;
        nib    = '0;
        diff   = '0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            diff   = ch - 8'h30;
            is_hex = 1'b1;
            nib    = diff[NIB_W-1:0];
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            diff   = ch - 8'h37;
            is_hex = 1'b1;
            nib    = diff[NIB_W-1:0];
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            diff   = ch - 8'h57;
            is_hex = 1'b1;
            nib    = diff[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/lrc_hex_encode.sv
module lrc_hex_encode
    import lrc_pkg::*;
(
    input  logic [NIB_W-1:0]  nib,
    output logic [CHAR_W-1:0] ch
);
    always_comb begin
        if (nib < 4'd10) ch = 8'h30 + {4'h0, nib};
        else             ch = 8'h37 + {4'h0, nib};
    end
endmodule

// File: rtl/ascii_lrc_engine.sv
module ascii_lrc_engine
    import lrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              in_ready,
    input  logic              tx_start,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              frame_done,
    output logic              frame_ok,
    output logic              lrc_error,
    output logic              fmt_error
);
    lrc_state_t s_q, s_d;

    logic              rx_hex;
    logic [NIB_W-1:0]  rx_nib;
    logic [NIB_W-1:0]  tx_nib;
    logic [CHAR_W-1:0] byte_now;
    logic [CHAR_W-1:0] total_now;
    logic              take;

    lrc_hex_decode u_dec (.ch(in_data), .is_hex(rx_hex), .nib(rx_nib));
    lrc_hex_encode u_enc (.nib(tx_nib), .ch(tx_data));

    assign in_ready  = (s_q.tx_ph == TX_OFF);
    assign take      = in_valid && in_ready;
    assign byte_now  = {s_q.nib, rx_nib};
    assign total_now = s_q.pend_v ? CHAR_W'(s_q.sum + s_q.pend) : s_q.sum;

    assign tx_valid   = (s_q.tx_ph != TX_OFF);
    assign tx_nib     = (s_q.tx_ph == TX_HI) ? s_q.tx_byte[CHAR_W-1:NIB_W]
                                             : s_q.tx_byte[NIB_W-1:0];
    assign frame_done = s_q.done;
    assign frame_ok   = s_q.ok;
    assign lrc_error  = s_q.lrc_err;
    assign fmt_error  = s_q.fmt_err;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.ok      = 1'b0;
        s_d.lrc_err = 1'b0;
        s_d.fmt_err = 1'b0;

        if (take) begin
            if (in_data == CH_COLON) begin
                s_d.fmt_err = (s_q.st != RX_IDLE);
                s_d.st      = RX_HI;
                s_d.sum     = '0;
                s_d.pend_v  = 1'b0;
            end else begin
                unique case (s_q.st)
                    RX_IDLE: ;
                    RX_HI: begin
                        if (rx_hex) begin
                            s_d.nib = rx_nib;
                            s_d.st  = RX_LO;
                        end else if (in_data == CH_CR) begin
                            s_d.st = RX_LF;
                        end else begin
                            s_d.fmt_err = 1'b1;
                            s_d.st      = RX_IDLE;
                        end
                    end
                    RX_LO: begin
                        if (rx_hex) begin
                            if (s_q.pend_v) s_d.sum = CHAR_W'(s_q.sum + s_q.pend);
                            s_d.pend   = byte_now;
                            s_d.pend_v = 1'b1;
                            s_d.st     = RX_HI;
                        end else begin
                            s_d.fmt_err = 1'b1;
                            s_d.st      = RX_IDLE;
                        end
                    end
                    RX_LF: begin
                        s_d.st = RX_IDLE;
                        if (in_data == CH_LF && s_q.pend_v) begin
                            s_d.done = 1'b1;
                            if (CHAR_W'(s_q.sum + s_q.pend) == '0) s_d.ok = 1'b1;
                            else                                   s_d.lrc_err = 1'b1;
                        end else begin
                            s_d.fmt_err = 1'b1;
                        end
                    end
                    default: s_d.st = RX_IDLE;
                endcase
            end
        end

        unique case (s_q.tx_ph)
            TX_OFF: if (tx_start) begin
                s_d.tx_ph   = TX_HI;
                s_d.tx_byte = CHAR_W'(8'h00 - total_now);
            end
            TX_HI: if (tx_ready) s_d.tx_ph = TX_LO;
            TX_LO: if (tx_ready) s_d.tx_ph = TX_OFF;
            default: s_d.tx_ph = TX_OFF;
        endcase

        if (rst) begin
            s_d       = '0;
            s_d.st    = RX_IDLE;
            s_d.tx_ph = TX_OFF;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // R10: done only after an accepted LF
    p_done_after_lf_r10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(in_valid && in_ready && in_data == CH_LF))
        else $error("frame_done without LF");

    // R2 / R3: a verdict always comes with frame_done, and only one verdict
    p_ok_implies_done_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_ok || lrc_error) |-> frame_done)
        else $error("verdict without frame_done");

    p_verdict_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_ok, lrc_error}))
        else $error("frame_ok and lrc_error together");

    p_fmt_not_done_r10: assert property (@(posedge clk) disable iff (rst)
        !(fmt_error && frame_done))
        else $error("fmt_error with frame_done");

    // R9: transmit data held under backpressure
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
        else $error("tx_data changed while stalled");

    // R8: only upper-case hex characters leave the transmitter
    p_tx_upper_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ((tx_data >= 8'h30 && tx_data <= 8'h39) ||
                      (tx_data >= 8'h41 && tx_data <= 8'h46)))
        else $error("tx_data not upper-case hex");

    // R8: receive stalled while transmitting
    p_rx_stall_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !in_ready)
        else $error("in_ready high during transmit");
endmodule

// File: tb/ascii_lrc_engine_bench.sv
module ascii_lrc_engine_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       tx_start;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready;
    logic       frame_done, frame_ok, lrc_error, fmt_error;

    int tests = 0;
    int fails = 0;
    logic [3:0] seen;   // {done, fmt, lrc, ok}

    always #2.5 clk = ~clk;

    ascii_lrc_engine u_ascii_lrc_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tx_start(tx_start), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .frame_done(frame_done),
        .frame_ok(frame_ok), .lrc_error(lrc_error), .fmt_error(fmt_error)
    );

    localparam int NV = 10;
    localparam logic [191:0] FR [NV] = '{
        ":010304010001F6\r\n",   // R2 reference example
        ":010304010001f6\r\n",   // R4 lower case check
        ":010304010001F7\r\n",   // R3 mismatch
        ":FF01\r\n",             // R2 sum FF, check 01
        ":00000000\r\n",         // R2 all zero
        ":01030401000\r\n",      // R6 odd count
        ":0103G4\r\n",           // R5 non-hex
        "zz\r\n5:0AF6\r\n",      // R1 junk before colon ignored
        ":0102:0af6\r\n",        // R7 colon restart then ok
        ":\r\n"                  // R6 no bytes
    };
    localparam logic [3:0] EXP [NV] = '{
        4'b1001, 4'b1001, 4'b1010, 4'b1001, 4'b1001,
        4'b0100, 4'b0100, 4'b1001, 4'b1101, 4'b0100
    };
    localparam string TAG [NV] = '{"R2", "R4", "R3", "R2", "R2",
                                   "R6", "R5", "R1", "R7", "R6"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = c;
        @(negedge clk);
        in_valid = 1'b0;
        seen |= {frame_done, fmt_error, lrc_error, frame_ok};
    endtask

    task automatic send_frame(input logic [191:0] f);
        seen = '0;
        for (int i = 23; i >= 0; i--) begin
            if (f[i*8 +: 8] != 8'h00) send_char(f[i*8 +: 8]);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n);
        return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tx_check(input string req, input logic [7:0] exp_byte);
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        check({req, " tx_valid"}, 32'(tx_valid), 32'd1);
        check({req, " in_ready low"}, 32'(in_ready), 32'd0);
        check({req, " hi char"}, 32'(tx_data), 32'(hexch(exp_byte[7:4])));
        @(negedge clk);
        @(negedge clk);
        check("R9 hi char held", 32'(tx_data), 32'(hexch(exp_byte[7:4])));
        check("R9 valid held", 32'(tx_valid), 32'd1);
        tx_ready = 1'b1;
        @(negedge clk);
        check({req, " lo char"}, 32'(tx_data), 32'(hexch(exp_byte[3:0])));
        @(negedge clk);
        check({req, " tx done"}, 32'(tx_valid), 32'd0);
        check({req, " in_ready back"}, 32'(in_ready), 32'd1);
        tx_ready = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; tx_start = 1'b0; tx_ready = 1'b0;
        seen = '0;
        do_reset();

        // R1 reset state
        check("R1 outputs after reset",
              {27'd0, frame_done, frame_ok, lrc_error, fmt_error, tx_valid}, 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            send_frame(FR[v]);
            check({TAG[v], " flags {done,fmt,lrc,ok}"}, 32'(seen), 32'(EXP[v]));
        end

        // R1 reset mid-frame returns to waiting for colon
        send_frame(":0103");
        do_reset();
        send_frame("0AF6\r\n");
        check("R1 no pulse after reset without colon", 32'(seen), 32'd0);

        // R8 transmit: bytes 01 03 04 01 00 01 -> F6
        send_frame(":010304010001");
        tx_check("R8 example", 8'h00 - (8'h01 + 8'h03 + 8'h04 + 8'h01 + 8'h00 + 8'h01));

        // R8 transmit with wrap: FF 01 FE -> 02
        do_reset();
        send_frame(":FF01fe");
        tx_check("R8 wrap", 8'h00 - (8'hFF + 8'h01 + 8'hFE));

        // R10 frame completes after transmit; check byte 02 makes sum zero
        send_frame("02\r\n");
        check("R10 frame after tx", 32'(seen), 32'b1001);

        // R10 LF without CR in a frame: fmt, no done
        send_frame(":0AF6\n");
        check("R10 LF without CR", 32'(seen), 32'b0100);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule